// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a processor operate a raw 8-bit NAND flash device through a single 32-bit memory-mapped word. A write to the word carries an operation code, a chip-enable level and one data byte. The operation code chooses one of four actions: a command latch cycle, an address latch cycle, a data byte write, or arming the read path. The bridge turns each latch or write into a timed strobe sequence on the flash pins. Setup, strobe-low and hold lengths are fixed clock counts.

Once the read path is armed, every register read fetches the next byte from the flash. The bridge pulses the read strobe, samples the data bus and completes the register read with that byte. While a flash strobe sequence is running, the register handshake stalls. A read of the word also reports the flash ready/busy line, passed through a synchronizer.

Top module: `nand_reg_bridge`

## Requirements
- R1: Write bits 30:28 select the action. Code 0 drives a write-strobe cycle with CLE high. Code 1 does the same with ALE high. Code 3 drives a write-strobe cycle with both CLE and ALE low. Each of these writes gives exactly one WE# pulse, and CLE and ALE are never high together.
- R2: On every write with code 0 to 3, bit 31 sets the chip enable. `nand_ce_n` is low when the bit is 1, and it keeps that level until the next such write.
- R3: During a latch or write sequence, bits 23:16 of the register write are driven on `nand_dq_out`, with `nand_dq_oe` high, and stay unchanged for the whole sequence.
- R4: A sequence holds 2 clocks of setup with CLE/ALE and data valid before WE# falls. WE# then stays low for 2 clocks, and 1 hold clock follows after WE# rises. `bus_ready` is low for exactly 5 cycles after the write is accepted.
- R5: A write with code 2 arms the read path without producing any WE# pulse. After that, each register read drives RE# low for 3 clocks and samples `nand_dq_in` on the last low clock. The read completes with that byte in bits 23:16, and successive reads return the successive flash bytes.
- R6: A write with code 0, 1 or 3 disarms the read path. An unarmed register read completes at once with the previously fetched byte and produces no RE# pulse.
- R7: Read bit 15 is 1 while `nand_rb_n` is low (the device is busy). A change of `nand_rb_n` shows in bit 15 no more than 3 clocks later.
- R8: Register bits other than 31, 30:28, 23:16 and 15 are ignored on write and read as zero. Codes 4 to 7 cause no strobe and change neither the chip enable nor the armed state.
- R9: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, CLE, ALE and `nand_dq_oe` are low, `bus_ready` is high, and the read word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request, held until accepted |
| bus_write | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Register write data |
| bus_ready | output | 1 | Access accepted on a clock edge where valid and ready are both high |
| bus_rdata | output | 32 | Register read word: byte in 23:16, busy in 15 |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
A latch or write accepted at edge k keeps CLE/ALE and data up from that edge. WE# falls at edge k+2 and rises at k+4, and `bus_ready` returns at k+5. The bench samples on falling edges and counts those five low-ready cycles. An armed read starting in cycle k keeps RE# low for cycles k to k+2. The bench flash model puts the real byte on the bus only in the third low cycle, so sampling in an earlier cycle returns a wrong value. The byte appears in cycle k+3. A `nand_rb_n` change is checked after three falling edges, which covers the two synchronizer stages.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int CE_BIT    = 31;
    localparam int OP_LSB    = 28;
    localparam int OP_W      = 3;
    localparam int DATA_LSB  = 16;
    localparam int BUSY_BIT  = 15;

    localparam logic [OP_W-1:0] OP_CMD   = 3'd0;
    localparam logic [OP_W-1:0] OP_ADDR  = 3'd1;
    localparam logic [OP_W-1:0] OP_ARM   = 3'd2;
    localparam logic [OP_W-1:0] OP_WDATA = 3'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WELOW,
        PH_HOLD,
        PH_RELOW
    } phase_t;

    typedef struct packed {
        logic              known;   // code 0..3
        logic              strobe;  // needs a WE# sequence
        logic              arm;     // arms the read path
        logic              cle;
        logic              ale;
        logic              ce;
        logic [BYTE_W-1:0] data;
    } req_t;

    function automatic req_t decode_word(input logic [REG_W-1:0] w);
        req_t r;
        logic [OP_W-1:0] op;
        op       = w[OP_LSB +: OP_W];
        r.known  = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_ARM) || (op == OP_WDATA);
        r.strobe = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WDATA);
        r.arm    = (op == OP_ARM);
        r.cle    = (op == OP_CMD);
        r.ale    = (op == OP_ADDR);
        r.ce     = w[CE_BIT];
        r.data   = w[DATA_LSB +: BYTE_W];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input logic [BYTE_W-1:0] b,
                                                   input logic busy);
        logic [REG_W-1:0] w;
        w                        = '0;
        w[DATA_LSB +: BYTE_W]    = b;
        w[BUSY_BIT]              = busy;
        return w;
    endfunction

endpackage

// File: rtl/nrb_decode.sv
module nrb_decode
    import nrb_pkg::*;
(
    input  logic [REG_W-1:0] word,
    output req_t             req
);
    always_comb req = decode_word(word);
endmodule

// File: rtl/nrb_rb_sync.sv
module nrb_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_n_async,
    output logic busy
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rb_n_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], rb_n_async};
            end
        end
    endgenerate

    assign busy = ~sync_q[STAGES-1];
endmodule

// File: rtl/nrb_strobe_seq.sv
module nrb_strobe_seq
    import nrb_pkg::*;
#(
    parameter int SETUP_CLKS  = 2,
    parameter int WE_LOW_CLKS = 2,
    parameter int HOLD_CLKS   = 1,
    parameter int RE_LOW_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              cle_in,
    input  logic              ale_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic              idle,
    output logic              capture,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int MAX_A   = (SETUP_CLKS > WE_LOW_CLKS) ? SETUP_CLKS : WE_LOW_CLKS;
    localparam int MAX_B   = (HOLD_CLKS > RE_LOW_CLKS) ? HOLD_CLKS : RE_LOW_CLKS;
    localparam int MAX_CLK = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_CLK > 1) ? $clog2(MAX_CLK) : 1;

    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] WE_LAST    = CNT_W'(WE_LOW_CLKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CLKS - 1);
    localparam logic [CNT_W-1:0] RE_LAST    = CNT_W'(RE_LOW_CLKS - 1);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cle_q, ale_q;
    logic [BYTE_W-1:0] data_q;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_wr) begin
                        phase_q <= PH_SETUP;
                        cle_q   <= cle_in;
                        ale_q   <= ale_in;
                        data_q  <= data_in;
                    end else if (start_rd) begin
                        phase_q <= PH_RELOW;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == SETUP_LAST) begin
                        phase_q <= PH_WELOW;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_WELOW: begin
                    if (cnt_q == WE_LAST) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_HOLD: begin
                    if (cnt_q == HOLD_LAST) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        cle_q   <= 1'b0;
                        ale_q   <= 1'b0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_RELOW: begin
                    if (cnt_q == RE_LAST) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign active  = (phase_q == PH_SETUP) || (phase_q == PH_WELOW) || (phase_q == PH_HOLD);
    assign idle    = (phase_q == PH_IDLE);
    assign capture = (phase_q == PH_RELOW) && (cnt_q == RE_LAST);
    assign cle     = active & cle_q;
    assign ale     = active & ale_q;
    assign we_n    = (phase_q != PH_WELOW);
    assign re_n    = (phase_q != PH_RELOW);
    assign dq_out  = data_q;
    assign dq_oe   = active;

    // R1: latch lines are mutually exclusive
    a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));
    // R3: driven byte does not move while the bus is driven
    a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
    // R5: never both strobes low
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        (we_n || re_n));
    // R4: bus is driven whenever WE# is low
    a_r4_oe_under_we: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nrb_pkg::*;
#(
    parameter int SETUP_CLKS  = 2,
    parameter int WE_LOW_CLKS = 2,
    parameter int HOLD_CLKS   = 1,
    parameter int RE_LOW_CLKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb_n
);
    req_t              req;
    logic              idle, capture, busy;
    logic              ce_q, armed_q, fresh_q;
    logic [BYTE_W-1:0] byte_q;
    logic              accept, start_wr, start_rd, pending_fetch;

    nrb_decode u_dec (
        .word (bus_wdata),
        .req  (req)
    );

    nrb_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .rb_n_async (nand_rb_n),
        .busy       (busy)
    );

    assign pending_fetch = bus_valid && !bus_write && armed_q && !fresh_q;
    assign bus_ready     = idle && !pending_fetch;
    assign accept        = bus_valid && bus_ready;
    assign start_wr      = accept && bus_write && req.strobe;
    assign start_rd      = idle && pending_fetch;

    nrb_strobe_seq #(
        .SETUP_CLKS  (SETUP_CLKS),
        .WE_LOW_CLKS (WE_LOW_CLKS),
        .HOLD_CLKS   (HOLD_CLKS),
        .RE_LOW_CLKS (RE_LOW_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .cle_in   (req.cle),
        .ale_in   (req.ale),
        .data_in  (req.data),
        .idle     (idle),
        .capture  (capture),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q    <= 1'b0;
            armed_q <= 1'b0;
            fresh_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            if (accept && bus_write && req.known) begin
                ce_q    <= req.ce;
                armed_q <= req.arm;
                fresh_q <= 1'b0;
            end
            if (accept && !bus_write) fresh_q <= 1'b0;
            if (capture) begin
                byte_q  <= nand_dq_in;
                fresh_q <= 1'b1;
            end
        end
    end

    assign nand_ce_n = ~ce_q;
    assign bus_rdata = pack_read(byte_q, busy);

    // R4: no register access is accepted while a strobe is low
    a_r4_stall_during_strobe: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !bus_ready);
    // R2: chip enable moves only after an accepted write
    a_r2_ce_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !$past(accept && bus_write) |-> $stable(nand_ce_n));
    // R8: unlisted read bits are zero
    a_r8_rdata_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & 32'hFF00_7FFF) == 32'h0);
    // R5: read strobe only starts for an armed read request
    a_r5_re_needs_request: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_re_n) |-> $past(bus_valid && !bus_write));
endmodule

// File: tb/sim_nand_reg_bridge.sv
`timescale 1ns/1ps
module sim_nand_reg_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb_n = 1'b1;

    int checks = 0, errors = 0, cycles = 0;
    int re_pulses = 0, rd_idx = 0, re_low = 0, we_low = 0, setup_cnt = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [9:0] exp_q[$];

    always #2.5 clk = ~clk;

    nand_reg_bridge u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    function automatic logic [7:0] flash_byte(input int i);
        return 8'h3C + 8'(i * 17);
    endfunction

    // flash model: real byte only in the third low RE# cycle
    assign nand_dq_in = (re_low == 3) ? flash_byte(rd_idx) : 8'hEE;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic ce, input logic [2:0] op,
                                       input logic [7:0] d, input logic [15:0] junk);
        return {ce, op, 4'hA, d, junk};   // bits 27:24 and 15:0 are junk
    endfunction

    // monitor / scoreboard on falling edges
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (nand_dq_oe && nand_we_n) setup_cnt++;
            if (!nand_dq_oe) setup_cnt = 0;
            if (!nand_we_n) we_low++;
            if (prev_we && !nand_we_n)
                chk(setup_cnt == 2, "R4 setup clocks", setup_cnt, 2);
            if (!prev_we && nand_we_n) begin
                chk(we_low == 2, "R4 WE low clocks", we_low, 2);
                chk(nand_dq_oe, "R4 hold clock", nand_dq_oe, 1);
                if (exp_q.size() == 0)
                    chk(1'b0, "R8 unexpected WE pulse", nand_dq_out, 0);
                else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk({nand_cle, nand_ale, nand_dq_out} == e, "R1 R3 latch/data",
                        {nand_cle, nand_ale, nand_dq_out}, e);
                end
                we_low = 0;
                setup_cnt = 0;
            end
            if (!nand_re_n) re_low++;
            if (!prev_re && nand_re_n) begin
                chk(re_low == 3, "R5 RE low clocks", re_low, 3);
                re_pulses++;
                rd_idx++;
                re_low = 0;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic wr(input logic [31:0] w);
        logic [2:0] op;
        op = w[30:28];
        if (op == 3'd0 || op == 3'd1 || op == 3'd3)
            exp_q.push_back({op == 3'd0, op == 3'd1, w[23:16]});
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = w;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic rd(output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    // cycles with ready low after an accepted write (called right after wr)
    task automatic stall_len(output int n);
        n = 0;
        @(negedge clk);
        while (!bus_ready) begin n++; @(negedge clk); end
    endtask

    initial begin : watchdog
        wait (cycles > 20000);
        chk(1'b0, "watchdog", cycles, 20000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        int n, p;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R9 strobes idle",
            {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk({nand_cle, nand_ale, nand_dq_oe} == 3'b000, "R9 latch lines",
            {nand_cle, nand_ale, nand_dq_oe}, 0);
        chk(bus_ready && bus_rdata == 0, "R9 ready/rdata", bus_rdata, 0);

        // R1 R2 command latch with chip enabled
        wr(mk(1'b1, 3'd0, 8'h90, 16'h0000));
        chk(nand_ce_n == 1'b0, "R2 CE asserted", nand_ce_n, 0);
        stall_len(n);
        chk(n == 5, "R4 stall length", n, 5);
        // address latch and data write with junk bits (R8)
        wr(mk(1'b1, 3'd1, 8'h00, 16'hFFFF));
        stall_len(n);
        wr(mk(1'b1, 3'd3, 8'hA5, 16'h7FFF));
        stall_len(n);
        chk(n == 5, "R4 stall length data write", n, 5);

        // R5 arm, then three reads in order
        p = re_pulses;
        wr(mk(1'b1, 3'd2, 8'h00, 16'h0000));
        stall_len(n);
        chk(n == 0 && exp_q.size() == 0, "R5 arm no strobe", n, 0);
        for (int i = 0; i < 3; i++) begin
            rd(d);
            chk(d[23:16] == flash_byte(i), "R5 read byte", d[23:16], flash_byte(i));
        end
        chk(re_pulses == p + 3, "R5 one RE pulse per read", re_pulses, p + 3);

        // R6 disarm with a command, unarmed read returns held byte
        wr(mk(1'b1, 3'd0, 8'hFF, 16'h0000));
        stall_len(n);
        p = re_pulses;
        rd(d);
        chk(d[23:16] == flash_byte(2), "R6 held byte", d[23:16], flash_byte(2));
        chk(re_pulses == p, "R6 no RE pulse", re_pulses, p);

        // R7 busy flag
        @(negedge clk); nand_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(d);
        chk(d[15] == 1'b1, "R7 busy set", d[15], 1);
        chk((d & 32'hFF00_7FFF) == 0, "R8 zero bits", d, {8'h0, d[23:16], 16'h8000});
        @(negedge clk); nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(d);
        chk(d[15] == 1'b0, "R7 busy clear", d[15], 0);

        // R8 unknown code ignored: CE kept, no strobe, not armed
        wr(mk(1'b0, 3'd5, 8'h12, 16'h0000));
        stall_len(n);
        chk(n == 0 && nand_ce_n == 1'b0, "R8 code 5 ignored", {n[30:0], nand_ce_n}, 0);
        p = re_pulses;
        rd(d);
        chk(re_pulses == p, "R8 code 5 does not arm", re_pulses, p);

        // R2 chip enable released
        wr(mk(1'b0, 3'd1, 8'h33, 16'h0000));
        chk(nand_ce_n == 1'b1, "R2 CE released", nand_ce_n, 1);
        stall_len(n);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all latches seen", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule